// File: doc/BRIEF.md
# Serial Port Register Block

This block is the processor-facing register file of a classic byte-wide serial port. A bus master reaches eight byte registers through a small address window. These registers are the transmit and receive data ports, the interrupt enable and identification registers, line control and modem control, line status and modem status, a scratch byte, and a 16-bit baud divisor. The divisor shares offsets 0 and 1 with the data and interrupt-enable registers, and a latch-access bit in line control selects it.

The serializer is not part of the block. A written transmit byte is offered on a valid/done handshake. A received byte arrives as a one-cycle strobe with its data. The interrupt identification is derived by priority. The transmit-empty source is tracked by a separate pending flag. That flag is set when a byte finishes and cleared either by a new transmit write or by a read of the identification register that reports it. A loopback mode makes the modem status register reflect the modem control outputs.

Reads return data combinationally in the cycle the read strobe is high. Read side effects take place at the clock edge that ends that cycle.

Top module: `sio_reg_block`

## Requirements
- R1: After reset, line status reads 0x60 (bit 6 transmitter empty, bit 5 holding register empty, bit 0 data ready clear), interrupt identification reads 0x01, the interrupt output is low and tx_valid is low.
- R2: Only the low three address bits select a register, so address 0x0F reaches the same register as address 0x07.
- R3: When line control bit 7 is set, offsets 0 and 1 write and read the low and high divisor bytes. Such a write does not start a transmission, and the divisor output shows the value.
- R4: Writing offset 0 with line control bit 7 clear clears line status bits 5 and 6 and clears the transmit pending flag. On the next cycle it raises tx_valid with the byte on tx_byte.
- R5: A tx_done pulse while tx_valid is high drops tx_valid and sets line status bits 5 and 6 and the transmit pending flag. A tx_done pulse while tx_valid is low has no effect.
- R6: Interrupt identification reads 0x04 when data ready and interrupt-enable bit 0 are both set. Otherwise it reads 0x02 when the transmit pending flag and interrupt-enable bit 1 are both set. Otherwise it reads 0x01. The interrupt output is high exactly when bit 0 of this value is zero.
- R7: A read of identification that returns 0x02 clears the transmit pending flag. A read that returns 0x04 or 0x01 leaves it unchanged.
- R8: A receive strobe stores the byte and sets line status bit 0. A read of offset 0 with bit 7 of line control clear returns the byte and clears that bit.
- R9: With modem control bit 4 set, modem status reads return modem control bits 3, 2, 0 and 1 on bits 7, 6, 5 and 4, with bits 3 to 0 zero.
- R10: With modem control bit 4 clear, modem status reads return the modem_status input as registered one cycle earlier.
- R11: Writes to offsets 5 (line status) and 6 (modem status) are ignored. Offset 7 is a plain read/write byte. Interrupt enable keeps only bits 3 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address; low three bits decoded |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | A byte waits to be serialized |
| tx_byte | output | 8 | Byte to serialize |
| tx_done | input | 1 | Serializer finished the byte |
| rx_strobe | input | 1 | Received byte present for one cycle |
| rx_byte | input | 8 | Received byte |
| modem_status | input | 8 | Modem status inputs |
| modem_ctrl | output | 4 | DTR, RTS, OUT1, OUT2 from modem control bits 0 to 3 |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line control value |

## Verification
Read data is combinational, so the bench samples bus_rdata a short delay after it drives a read. A register written in one cycle can be read from the next cycle on. tx_valid, tx_byte and the status bits change at the edge that ends a write or tx_done cycle, and irq follows the identification value in the same cycle. The clear caused by an identification read only shows on the next access. Modem status inputs need one cycle to reach the register. For these reasons every task drives on the falling edge, samples after at least one rising edge has passed, and puts an idle cycle between accesses.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DW    = 8;
  localparam int OFS_W = 3;
  localparam int DIV_W = 2 * DW;

  typedef enum logic [OFS_W-1:0] {
    OFS_DATA = 3'd0, OFS_IEN = 3'd1, OFS_IID = 3'd2, OFS_LCTL = 3'd3,
    OFS_MCTL = 3'd4, OFS_LSTS = 3'd5, OFS_MSTS = 3'd6, OFS_SCR = 3'd7
  } ofs_e;

  localparam logic [DW-1:0] ID_NONE = 8'h01;
  localparam logic [DW-1:0] ID_TXE  = 8'h02;
  localparam logic [DW-1:0] ID_RXD  = 8'h04;

  localparam int LCTL_DLAB = 7;
  localparam int IEN_RX    = 0;
  localparam int IEN_TX    = 1;
  localparam int MCTL_LOOP = 4;

  function automatic logic [DW-1:0] id_code(logic dr, logic rx_en,
                                           logic pend, logic tx_en);
    if (dr && rx_en)        return ID_RXD;
    else if (pend && tx_en) return ID_TXE;
    else                    return ID_NONE;
  endfunction

  function automatic logic [DW-1:0] loop_status(logic [DW-1:0] mctl);
    return {mctl[3], mctl[2], mctl[0], mctl[1], 4'b0000};
  endfunction

  function automatic logic [DW-1:0] line_status(logic dr, logic thre, logic temt);
    return {1'b0, temt, thre, 4'b0000, dr};
  endfunction
endpackage

// File: rtl/sio_tx_path.sv
module sio_tx_path
  import sio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          thr_wr,
  input  logic [DW-1:0] wdata,
  input  logic          pend_clr,
  input  logic          tx_done,
  output logic          tx_valid,
  output logic [DW-1:0] tx_byte,
  output logic          thre,
  output logic          temt,
  output logic          pend,
  output logic          tx_complete
);
  assign tx_complete = tx_done && tx_valid && !thr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
      thre     <= 1'b1;
      temt     <= 1'b1;
      pend     <= 1'b0;
    end else if (thr_wr) begin
      tx_valid <= 1'b1;
      tx_byte  <= wdata;
      thre     <= 1'b0;
      temt     <= 1'b0;
      pend     <= 1'b0;
    end else if (tx_complete) begin
      tx_valid <= 1'b0;
      thre     <= 1'b1;
      temt     <= 1'b1;
      pend     <= 1'b1;
    end else if (pend_clr) begin
      pend     <= 1'b0;
    end
  end

  // R4: a transmit write takes the holding register and starts the handshake
  p_wr_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (tx_valid && !thre && !temt && !pend));
  // R5: completion frees the holding register and raises the pending flag
  p_done_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_complete |=> (!tx_valid && thre && temt && pend));
  // R5: a done pulse with nothing in flight changes nothing
  p_idle_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_valid && !thr_wr && !pend_clr) |=> ($stable(thre) && $stable(pend) && !tx_valid));
  // R4: the offered byte holds while waiting
  p_byte_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !thr_wr) |=> $stable(tx_byte));
endmodule

// File: rtl/sio_rx_path.sv
module sio_rx_path
  import sio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_strobe,
  input  logic [DW-1:0] rx_byte,
  input  logic          rbr_rd,
  output logic          dr,
  output logic [DW-1:0] rbr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr  <= 1'b0;
      rbr <= '0;
    end else if (rx_strobe) begin
      dr  <= 1'b1;
      rbr <= rx_byte;
    end else if (rbr_rd) begin
      dr  <= 1'b0;
    end
  end

  // R8: arrival sets data ready, a read of the byte clears it
  p_rx_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> dr);
  p_rd_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && !rx_strobe) |=> !dr);
endmodule

// File: rtl/sio_ctrl_regs.sv
module sio_ctrl_regs
  import sio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [OFS_W-1:0] ofs,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    msts_in,
  output logic [DW-1:0]    ien,
  output logic [DW-1:0]    lctl,
  output logic [DW-1:0]    mctl,
  output logic [DW-1:0]    scr,
  output logic [DW-1:0]    msts,
  output logic [DIV_W-1:0] div
);
  logic dlab;
  assign dlab = lctl[LCTL_DLAB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msts <= '0;
    else        msts <= msts_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien  <= '0;
      lctl <= '0;
      mctl <= '0;
      scr  <= '0;
      div  <= '0;
    end else if (wr) begin
      case (ofs_e'(ofs))
        OFS_DATA: if (dlab) div[DW-1:0] <= wdata;
        OFS_IEN:  if (dlab) div[DIV_W-1:DW] <= wdata;
                  else      ien <= {4'b0000, wdata[3:0]};
        OFS_LCTL: lctl <= wdata;
        OFS_MCTL: mctl <= {3'b000, wdata[4:0]};
        OFS_SCR:  scr  <= wdata;
        default: ;
      endcase
    end
  end

  // R11: the upper half of interrupt enable never holds a one
  p_ien_upper_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ien[DW-1:4] == '0);
  // R3: the divisor changes only through a latch-access write
  p_div_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && dlab) |=> $stable(div));
endmodule

// File: rtl/sio_reg_block.sv
module sio_reg_block
  import sio_pkg::*;
#(
  parameter int BUS_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_done,
  input  logic              rx_strobe,
  input  logic [7:0]        rx_byte,
  input  logic [7:0]        modem_status,
  output logic [3:0]        modem_ctrl,
  output logic [15:0]       divisor,
  output logic [7:0]        line_ctrl
);
  logic [OFS_W-1:0] ofs;
  logic [DW-1:0]    ien, lctl, mctl, scr, msts, rbr, iid;
  logic [DIV_W-1:0] div;
  logic             dlab, dr, thre, temt, pend, tx_complete;
  logic             thr_wr, rbr_rd, iid_rd, pend_clr;

  assign ofs      = bus_addr[OFS_W-1:0];
  assign dlab     = lctl[LCTL_DLAB];
  assign thr_wr   = bus_wr && (ofs == OFS_DATA) && !dlab;
  assign rbr_rd   = bus_rd && (ofs == OFS_DATA) && !dlab;
  assign iid_rd   = bus_rd && (ofs == OFS_IID);
  assign iid      = id_code(dr, ien[IEN_RX], pend, ien[IEN_TX]);
  assign pend_clr = iid_rd && (iid[2:0] == ID_TXE[2:0]);
  assign irq      = !iid[0];

  sio_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .ofs(ofs), .wdata(bus_wdata),
    .msts_in(modem_status), .ien(ien), .lctl(lctl), .mctl(mctl),
    .scr(scr), .msts(msts), .div(div)
  );

  sio_tx_path u_tx (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .wdata(bus_wdata),
    .pend_clr(pend_clr), .tx_done(tx_done), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .thre(thre), .temt(temt), .pend(pend),
    .tx_complete(tx_complete)
  );

  sio_rx_path u_rx (
    .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
    .rbr_rd(rbr_rd), .dr(dr), .rbr(rbr)
  );

  always_comb begin
    case (ofs_e'(ofs))
      OFS_DATA: bus_rdata = dlab ? div[DW-1:0] : rbr;
      OFS_IEN:  bus_rdata = dlab ? div[DIV_W-1:DW] : ien;
      OFS_IID:  bus_rdata = iid;
      OFS_LCTL: bus_rdata = lctl;
      OFS_MCTL: bus_rdata = mctl;
      OFS_LSTS: bus_rdata = line_status(dr, thre, temt);
      OFS_MSTS: bus_rdata = mctl[MCTL_LOOP] ? loop_status(mctl) : msts;
      default:  bus_rdata = scr;
    endcase
  end

  assign modem_ctrl = mctl[3:0];
  assign divisor    = div;
  assign line_ctrl  = lctl;

  // R6: identification always carries exactly one of the three codes
  p_iid_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(iid[2:0]) && (iid[DW-1:3] == '0));
  // R7: a read reporting transmit-empty removes that source
  p_iid_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !tx_complete) |=> !pend);
  // R7: a read reporting receive data keeps the transmit source
  p_iid_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_rd && (iid[2:0] == ID_RXD[2:0]) && !thr_wr) |=> $stable(pend));
  // R3: latch-access writes to offset 0 never reach the transmitter
  p_dlab_no_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && dlab && (ofs == OFS_DATA) && !tx_valid) |=> !tx_valid);
endmodule

// File: tb/sio_reg_block_tb.sv
module sio_reg_block_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0, bus_wdata = '0, rx_byte = '0, modem_status = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, tx_done = 1'b0, rx_strobe = 1'b0;
  logic [7:0]  bus_rdata, tx_byte, line_ctrl;
  logic        irq, tx_valid;
  logic [3:0]  modem_ctrl;
  logic [15:0] divisor;
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_reg_block u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_done(tx_done),
    .rx_strobe(rx_strobe), .rx_byte(rx_byte), .modem_status(modem_status),
    .modem_ctrl(modem_ctrl), .divisor(divisor), .line_ctrl(line_ctrl)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_check(string req, logic [7:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, {8'h00, d}, {8'h00, exp});
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic push_rx(logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_strobe = 1'b1;
    @(negedge clk); rx_strobe = 1'b0;
  endtask

  task automatic t_reset();
    rd_check("R1 lsr", 8'h05, 8'h60);
    rd_check("R1 iid", 8'h02, 8'h01);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 tx_valid", {15'd0, tx_valid}, 16'd0);
  endtask

  task automatic t_scratch_alias();
    wr(8'h07, 8'hA5);
    rd_check("R11 scratch", 8'h07, 8'hA5);
    rd_check("R2 alias read", 8'h0F, 8'hA5);
    wr(8'h17, 8'h3C);
    rd_check("R2 alias write", 8'h07, 8'h3C);
  endtask

  task automatic t_divisor();
    wr(8'h03, 8'h83);
    wr(8'h00, 8'h34);
    wr(8'h01, 8'h12);
    check("R3 no tx", {15'd0, tx_valid}, 16'd0);
    rd_check("R3 div lo", 8'h00, 8'h34);
    rd_check("R3 div hi", 8'h01, 8'h12);
    check("R3 divisor out", divisor, 16'h1234);
    rd_check("R3 lsr untouched", 8'h05, 8'h60);
    wr(8'h03, 8'h03);
    rd_check("R3 ien back", 8'h01, 8'h00);
    check("R3 line_ctrl", {8'h00, line_ctrl}, 16'h0003);
  endtask

  task automatic t_transmit();
    wr(8'h00, 8'h5A);
    check("R4 tx_valid", {15'd0, tx_valid}, 16'd1);
    check("R4 tx_byte", {8'h00, tx_byte}, 16'h005A);
    rd_check("R4 lsr busy", 8'h05, 8'h00);
    pulse_done();
    check("R5 tx_valid drop", {15'd0, tx_valid}, 16'd0);
    rd_check("R5 lsr free", 8'h05, 8'h60);
    rd_check("R6 masked", 8'h02, 8'h01);
    check("R6 irq masked", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_tx_irq();
    wr(8'h01, 8'hF2);
    rd_check("R11 ien low nibble", 8'h01, 8'h02);
    check("R6 irq tx", {15'd0, irq}, 16'd1);
    rd_check("R6 txe code", 8'h02, 8'h02);
    check("R7 irq cleared", {15'd0, irq}, 16'd0);
    rd_check("R7 after clear", 8'h02, 8'h01);
  endtask

  task automatic t_priority();
    wr(8'h00, 8'h11);
    pulse_done();
    push_rx(8'h77);
    wr(8'h01, 8'h03);
    rd_check("R8 lsr dr", 8'h05, 8'h61);
    rd_check("R6 rx first", 8'h02, 8'h04);
    rd_check("R7 kept", 8'h02, 8'h04);
    rd_check("R8 rbr", 8'h00, 8'h77);
    rd_check("R8 dr cleared", 8'h05, 8'h60);
    rd_check("R6 tx next", 8'h02, 8'h02);
    rd_check("R7 then none", 8'h02, 8'h01);
    pulse_done();
    rd_check("R5 idle done", 8'h02, 8'h01);
    check("R5 idle tx_valid", {15'd0, tx_valid}, 16'd0);
  endtask

  task automatic t_modem();
    wr(8'h04, 8'h1D);
    rd_check("R9 loop a", 8'h06, 8'hE0);
    wr(8'h04, 8'h12);
    rd_check("R9 loop b", 8'h06, 8'h10);
    @(negedge clk); modem_status = 8'hB3;
    wr(8'h04, 8'h0F);
    check("R10 modem_ctrl", {12'd0, modem_ctrl}, 16'h000F);
    rd_check("R10 status", 8'h06, 8'hB3);
    wr(8'h05, 8'h00);
    rd_check("R11 lsr write ignored", 8'h05, 8'h60);
    wr(8'h06, 8'hFF);
    rd_check("R11 msr write ignored", 8'h06, 8'hB3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_scratch_alias();
    t_divisor();
    t_transmit();
    t_tx_irq();
    t_priority();
    t_modem();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule